// File: doc/BRIEF.md
# Character display power-up sequencer

This block runs on the host side of a character display. After power-up it moves the display controller into 4-bit bus mode with two lines and a 5x7 font. It does not touch the bus pins. Every bus action is a request to a downstream transfer engine over a request/acknowledge handshake. The request says what kind of transfer to make:

- a lone high nibble,
- a full byte split into two nibbles, or
- a busy-flag read.

While the controller is still in its unknown wake-up state, the busy flag cannot be trusted. During this phase the sequencer sends three "8-bit function set" nibbles and one "switch to 4-bit" nibble. It spaces them only by fixed delays, which are counted in clock cycles derived from `CLK_HZ`.

Once the bus is in 4-bit mode, the sequencer sends five setup commands: function set, display off, display on, entry mode, and clear. Before each one it polls the busy flag until the controller reports idle. When the clear command is acknowledged, `init_done` goes high and stays high until the next start request. The line count and font are fixed by the 4-bit function-set command and are never sent again.

Top module: `lcd_boot_seq`

## Requirements
- R1: After reset, and until `start` is seen, `xfer_req` and `init_done` stay low.
- R2: The first request after an accepted `start` rises more than 15 ms worth of `CLK_HZ` cycles later.
- R3: Three blind nibble requests come first. Each has `xfer_op` = 0 (nibble) and `xfer_data` = 8'h03. The gap from the acknowledge of the first to the next request exceeds 4.1 ms of cycles. The gap after the second exceeds 100 us of cycles. No busy poll occurs before the 4-bit switch.
- R4: After the third wake-up nibble there is a further wait of more than 100 us of cycles. Then one nibble request with `xfer_data` = 8'h02 is issued.
- R5: Five commands follow, each with `xfer_op` = 1 (byte), in this order: 8'h28, 8'h08, 8'h0C, 8'h06, 8'h01. Each is preceded by a busy poll with `xfer_op` = 2 and `xfer_data` = 8'h00. The poll is repeated for as long as `busy_flag` is 1 in the acknowledge cycle.
- R6: A raised `xfer_req` keeps `xfer_op` and `xfer_data` stable until `xfer_ack`. `xfer_req` is low in the cycle after each acknowledge.
- R7: `init_done` rises only after the clear command (8'h01) is acknowledged. It then stays high with `xfer_req` low.
- R8: A `start` pulse while the sequence is running has no effect. This includes a pulse that arrives in the same cycle as the final acknowledge.
- R9: A `start` seen while `init_done` is high drops `init_done` and replays the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence |
| xfer_req | output | 1 | Transfer request to the bus engine |
| xfer_op | output | 2 | Transfer kind: 0 nibble, 1 byte, 2 busy poll |
| xfer_data | output | 8 | Nibble in bits 3:0, or the full command byte |
| xfer_ack | input | 1 | One-cycle acknowledge from the bus engine |
| busy_flag | input | 1 | Busy bit read by a poll, valid with `xfer_ack` |
| init_done | output | 1 | Sequence complete |

## Verification
Two events can land on the same clock edge: the acknowledge of the last command, and a fresh `start` request. The bench's bus model raises `start` in exactly the cycle in which it acknowledges the clear byte. Correct behaviour is that `init_done` rises on the following edge and that no further request appears afterwards, showing the start was ignored rather than treated as a restart. A second run answers each busy poll with two busy replies, so the retry path is exercised while the command order is held to the same expected table.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

    localparam int unsigned NSTEP = 9;
    localparam int unsigned IDX_W = $clog2(NSTEP);

    localparam logic [7:0] WAKE_8BIT    = 8'h03;
    localparam logic [7:0] WAKE_4BIT    = 8'h02;
    localparam logic       TWO_LINES    = 1'b1;
    localparam logic       FONT_TALL    = 1'b0;
    localparam logic [7:0] CMD_FUNC     = 8'h20 | {4'b0000, TWO_LINES, FONT_TALL, 2'b00};
    localparam logic [7:0] CMD_DISP_OFF = 8'h08;
    localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
    localparam logic [7:0] CMD_ENTRY    = 8'h06;
    localparam logic [7:0] CMD_CLEAR    = 8'h01;

    typedef enum logic [1:0] {
        XOP_NIBBLE = 2'd0,
        XOP_BYTE   = 2'd1,
        XOP_POLL   = 2'd2
    } xop_e;

    typedef enum logic [1:0] {
        PRE_POWER = 2'd0,
        PRE_LONG  = 2'd1,
        PRE_SHORT = 2'd2,
        PRE_BUSY  = 2'd3
    } pre_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ENTER, ST_DELAY, ST_POLL, ST_REPOLL, ST_ARM, ST_SEND, ST_DONE
    } fsm_e;

    typedef struct packed {
        pre_e       pre;
        xop_e       op;
        logic [7:0] data;
    } step_t;

    function automatic step_t script_step(input logic [IDX_W-1:0] i);
        step_t s;
        case (i)
            IDX_W'(0): s = '{pre: PRE_POWER, op: XOP_NIBBLE, data: WAKE_8BIT};
            IDX_W'(1): s = '{pre: PRE_LONG,  op: XOP_NIBBLE, data: WAKE_8BIT};
            IDX_W'(2): s = '{pre: PRE_SHORT, op: XOP_NIBBLE, data: WAKE_8BIT};
            IDX_W'(3): s = '{pre: PRE_SHORT, op: XOP_NIBBLE, data: WAKE_4BIT};
            IDX_W'(4): s = '{pre: PRE_BUSY,  op: XOP_BYTE,   data: CMD_FUNC};
            IDX_W'(5): s = '{pre: PRE_BUSY,  op: XOP_BYTE,   data: CMD_DISP_OFF};
            IDX_W'(6): s = '{pre: PRE_BUSY,  op: XOP_BYTE,   data: CMD_DISP_ON};
            IDX_W'(7): s = '{pre: PRE_BUSY,  op: XOP_BYTE,   data: CMD_ENTRY};
            default:   s = '{pre: PRE_BUSY,  op: XOP_BYTE,   data: CMD_CLEAR};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_boot_script.sv
module lcd_boot_script
    import lcd_boot_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    always_comb begin
        step = script_step(idx);
    end

endmodule

// File: rtl/lcd_boot_timer.sv
module lcd_boot_timer
    import lcd_boot_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  pre_e sel,
    output logic zero
);

    // Each wait is one cycle longer than the minimum, so it strictly exceeds it.
    localparam longint unsigned CYC_POWER = (longint'(CLK_HZ) * 15) / 1000 + 1;
    localparam longint unsigned CYC_LONG  = (longint'(CLK_HZ) * 41) / 10000 + 1;
    localparam longint unsigned CYC_SHORT = longint'(CLK_HZ) / 10000 + 1;
    localparam int unsigned     CNT_W     = $clog2(CYC_POWER + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        case (sel)
            PRE_POWER: load_val = CNT_W'(CYC_POWER - 1);
            PRE_LONG:  load_val = CNT_W'(CYC_LONG - 1);
            PRE_SHORT: load_val = CNT_W'(CYC_SHORT - 1);
            default:   load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_WAIT_ARMED: assert property (@(posedge clk) disable iff (rst)
        load && sel != PRE_BUSY |=> !zero);  // R2

endmodule

// File: rtl/lcd_boot_fsm.sv
module lcd_boot_fsm
    import lcd_boot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             xfer_ack,
    input  logic             busy_flag,
    input  logic             tmr_zero,
    input  step_t            step,
    output logic [IDX_W-1:0] idx,
    output logic             tmr_load,
    output pre_e             tmr_sel,
    output logic             xfer_req,
    output xop_e             xfer_op,
    output logic [7:0]       xfer_data,
    output logic             init_done
);

    fsm_e state;
    logic last_step;
    logic four_bit;

    assign last_step = (idx == IDX_W'(NSTEP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (start) begin
                    idx   <= '0;
                    state <= ST_ENTER;
                end
                ST_ENTER:  state <= (step.pre == PRE_BUSY) ? ST_POLL : ST_DELAY;
                ST_DELAY:  if (tmr_zero) state <= ST_SEND;
                ST_POLL:   if (xfer_ack) state <= busy_flag ? ST_REPOLL : ST_ARM;
                ST_REPOLL: state <= ST_POLL;
                ST_ARM:    state <= ST_SEND;
                ST_SEND:   if (xfer_ack) begin
                    if (last_step) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_ENTER;
                    end
                end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign tmr_load  = (state == ST_ENTER) && (step.pre != PRE_BUSY);
    assign tmr_sel   = step.pre;
    assign xfer_req  = (state == ST_POLL) || (state == ST_SEND);
    assign xfer_op   = (state == ST_POLL) ? XOP_POLL : step.op;
    assign xfer_data = (state == ST_POLL) ? 8'h00 : step.data;
    assign init_done = (state == ST_DONE);

    // Tracks whether the bus has been switched to 4-bit mode in this run.
    always_ff @(posedge clk) begin
        if (rst)
            four_bit <= 1'b0;
        else if ((state == ST_IDLE || state == ST_DONE) && start)
            four_bit <= 1'b0;
        else if (state == ST_SEND && xfer_ack && step.op == XOP_NIBBLE && step.data == WAKE_4BIT)
            four_bit <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_op) && $stable(xfer_data));  // R6
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        xfer_req && xfer_ack |=> !xfer_req);  // R6
    AST_NIBBLE_BLIND: assert property (@(posedge clk) disable iff (rst)
        xfer_req && xfer_op == XOP_NIBBLE |-> !four_bit);  // R3
    AST_POLL_LATE: assert property (@(posedge clk) disable iff (rst)
        xfer_req && xfer_op != XOP_NIBBLE |-> four_bit);  // R5
    AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(xfer_req && xfer_ack && xfer_op == XOP_BYTE && xfer_data == CMD_CLEAR));  // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        init_done |-> !xfer_req);  // R7

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
    import lcd_boot_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       xfer_req,
    output logic [1:0] xfer_op,
    output logic [7:0] xfer_data,
    input  logic       xfer_ack,
    input  logic       busy_flag,
    output logic       init_done
);

    logic [IDX_W-1:0] idx;
    step_t            step;
    logic             tmr_load;
    pre_e             tmr_sel;
    logic             tmr_zero;
    xop_e             op_int;

    lcd_boot_script u_script (
        .idx  (idx),
        .step (step)
    );

    lcd_boot_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .sel  (tmr_sel),
        .zero (tmr_zero)
    );

    lcd_boot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .xfer_ack  (xfer_ack),
        .busy_flag (busy_flag),
        .tmr_zero  (tmr_zero),
        .step      (step),
        .idx       (idx),
        .tmr_load  (tmr_load),
        .tmr_sel   (tmr_sel),
        .xfer_req  (xfer_req),
        .xfer_op   (op_int),
        .xfer_data (xfer_data),
        .init_done (init_done)
    );

    assign xfer_op = op_int;

    AST_QUIET_UNTIL_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && !start |=> !xfer_req && !init_done);  // R1

endmodule

// File: tb/lcd_boot_seq_test.sv
`timescale 1ns/1ps
module lcd_boot_seq_test;

    localparam int unsigned CLK_HZ = 100_000;
    localparam int MS15   = CLK_HZ * 15 / 1000;
    localparam int MS4P1  = CLK_HZ * 41 / 10000;
    localparam int US100  = CLK_HZ / 10000;
    localparam int SLACK  = 6;
    localparam int LAT    = 2;
    localparam int NEXP   = 14;
    // {op, data}: op 0 nibble, 1 byte, 2 poll
    localparam logic [9:0] EXP [0:NEXP-1] = '{
        {2'd0, 8'h03}, {2'd0, 8'h03}, {2'd0, 8'h03}, {2'd0, 8'h02},
        {2'd2, 8'h00}, {2'd1, 8'h28}, {2'd2, 8'h00}, {2'd1, 8'h08},
        {2'd2, 8'h00}, {2'd1, 8'h0C}, {2'd2, 8'h00}, {2'd1, 8'h06},
        {2'd2, 8'h00}, {2'd1, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start;
    logic       start_m = 1'b0;
    logic       start_r = 1'b0;
    logic       xfer_req;
    logic [1:0] xfer_op;
    logic [7:0] xfer_data;
    logic       xfer_ack = 1'b0;
    logic       busy_flag = 1'b0;
    logic       init_done;

    assign start = start_m | start_r;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    int         busy_k = 0;
    int         busy_left = 0;
    bit         coincide = 0;
    int         n_log = 0;
    int         poll_rep = 0;
    logic [9:0] lg_ent [0:63];
    int         lg_rise [0:63];
    int         lg_ack [0:63];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_boot_seq #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst(rst), .start(start), .xfer_req(xfer_req), .xfer_op(xfer_op),
        .xfer_data(xfer_data), .xfer_ack(xfer_ack), .busy_flag(busy_flag), .init_done(init_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus engine model: acknowledges after LAT sampled cycles, answers polls.
    initial begin : responder
        bit         pend = 0;
        int         waited = 0;
        int         rise = 0;
        bit         hold_ok = 1;
        logic [9:0] cap = '0;
        forever begin
            @(negedge clk);
            start_r = 1'b0;
            if (xfer_ack) begin
                xfer_ack  = 1'b0;
                busy_flag = 1'b0;
                check(xfer_req == 1'b0, "R6 req low after ack", xfer_req, 0);
            end else if (xfer_req && !rst) begin
                if (!pend) begin
                    pend = 1; waited = 0; rise = cyc; hold_ok = 1;
                    cap = {xfer_op, xfer_data};
                end else if ({xfer_op, xfer_data} != cap) begin
                    hold_ok = 0;
                end
                waited++;
                if (waited == LAT) begin
                    pend = 0;
                    xfer_ack = 1'b1;
                    check(hold_ok, "R6 op/data held until ack", 0, 1);
                    if (xfer_op == 2'd2) begin
                        busy_flag = (busy_left > 0);
                        if (busy_left > 0) busy_left--;
                    end
                    if (xfer_op != 2'd2) busy_left = busy_k;
                    if (xfer_op == 2'd2 && n_log > 0 && lg_ent[n_log-1][9:8] == 2'd2) begin
                        poll_rep++;
                    end else if (n_log < 64) begin
                        lg_ent[n_log]  = cap;
                        lg_rise[n_log] = rise;
                        lg_ack[n_log]  = cyc;
                        n_log++;
                    end
                    if (coincide && xfer_op == 2'd1 && xfer_data == 8'h01) start_r = 1'b1;
                end
            end
        end
    end

    task automatic pulse_start();
        start_m = 1'b1;
        @(negedge clk);
        start_m = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !init_done; i++) @(negedge clk);
    endtask

    task automatic check_run(input int base, input int s_cyc, input int rep_base, input int exp_rep);
        check(n_log - base == NEXP, "R5 transaction count", n_log - base, NEXP);
        for (int i = 0; i < NEXP; i++) begin
            check(lg_ent[base+i] == EXP[i], (i < 3) ? "R3 wake nibble" : (i == 3) ? "R4 4-bit nibble" : "R5 command/poll order",
                  lg_ent[base+i], EXP[i]);
        end
        check(lg_rise[base] - s_cyc > MS15 && lg_rise[base] - s_cyc <= MS15 + SLACK,
              "R2 power-up wait", lg_rise[base] - s_cyc, MS15 + 1);
        check(lg_rise[base+1] - lg_ack[base] > MS4P1 && lg_rise[base+1] - lg_ack[base] <= MS4P1 + SLACK,
              "R3 wait after first nibble", lg_rise[base+1] - lg_ack[base], MS4P1 + 1);
        check(lg_rise[base+2] - lg_ack[base+1] > US100 && lg_rise[base+2] - lg_ack[base+1] <= US100 + SLACK,
              "R3 wait after second nibble", lg_rise[base+2] - lg_ack[base+1], US100 + 1);
        check(lg_rise[base+3] - lg_ack[base+2] > US100 && lg_rise[base+3] - lg_ack[base+2] <= US100 + SLACK,
              "R4 wait before 4-bit nibble", lg_rise[base+3] - lg_ack[base+2], US100 + 1);
        check(poll_rep - rep_base == exp_rep, "R5 busy poll repeats", poll_rep - rep_base, exp_rep);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int base;
        int s_cyc;
        int rb;
        bit quiet;

        // R1: reset and idle without start
        repeat (4) @(negedge clk);
        rst = 1'b0;
        quiet = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (xfer_req || init_done) quiet = 0;
        end
        check(quiet, "R1 idle until start", {xfer_req, init_done}, 0);

        // Run 1: no busy replies, start ignored mid-wait and at the final ack
        busy_k = 0; busy_left = 0; coincide = 1;
        base = n_log; rb = poll_rep; s_cyc = cyc;
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();                             // R8 mid-run start
        wait_done(20000);
        check(init_done == 1'b1, "R7 done after clear", init_done, 1);
        check(lg_ack[n_log-1] + 1 == cyc, "R7 done one cycle after clear ack", cyc, lg_ack[n_log-1] + 1);
        quiet = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (xfer_req || !init_done) quiet = 0;
        end
        check(quiet, "R8 start at final ack ignored; R7 done holds", {xfer_req, init_done}, 1);
        check_run(base, s_cyc, rb, 0);
        coincide = 0;

        // Run 2: restart from done, two busy replies per poll
        busy_k = 2; busy_left = 2;
        base = n_log; rb = poll_rep; s_cyc = cyc;
        pulse_start();
        check(init_done == 1'b0, "R9 done drops on restart", init_done, 0);
        wait_done(20000);
        check(init_done == 1'b1, "R9 replay completes", init_done, 1);
        check_run(base, s_cyc, rb, 10);

        // R1: reset in the middle of a run
        pulse_start();
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!xfer_req && !init_done, "R1 reset clears run", {xfer_req, init_done}, 0);
        rst = 1'b0;
        quiet = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (xfer_req) quiet = 0;
        end
        check(quiet, "R1 no request after reset", xfer_req, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule